// File: doc/BRIEF.md
# Power-Saving Light Measurement Scheduler

This block sequences the measurements of a light-to-digital front end. It raises an integrate-enable output for a window whose length comes from a 4-bit integration-time code. When that window ends, it captures the front end's ambient and white-channel results into held output registers and pulses a result-valid strobe. When power saving is off, windows follow one another with no gap. When power saving is on, each window is followed by an idle wait of 500, 1000, 2000 or 4000 ms, chosen by a 2-bit mode. The refresh period is then the integration time plus that wait.

All timing is counted in pulses of a one-millisecond tick input, so the block runs from any fast clock. In shutdown the block stops measuring but keeps the last results on its outputs. When shutdown is released, a new window opens immediately. The configuration inputs are sampled only when a window opens, so software may change them at any time without cutting a window short.

Top module: `meas_sched`

## Requirements
- R1: After reset the block is in shutdown: `integ_en` and `res_valid` are low and both result outputs are zero.
- R2: Integration-time codes map to window lengths in ms ticks as follows: 4'b1100 gives 25, 4'b1000 gives 50, 4'b0000 gives 100, 4'b0001 gives 200, 4'b0010 gives 400 and 4'b0011 gives 800.
- R3: Any integration-time code not listed in R2 gives a 100-tick window.
- R4: With `psm_en` low, a new window opens on the same clock edge that ends the previous one, so results arrive every integration time.
- R5: With `psm_en` high, each window is followed by an idle period with `integ_en` low. The idle period lasts 500, 1000, 2000 or 4000 ticks for `psm_mode` 2'b00, 2'b01, 2'b10 and 2'b11 respectively. For example, a 100-tick window in mode 00 repeats every 600 ticks, and an 800-tick window in mode 11 repeats every 4800 ticks.
- R6: On the edge that counts a window's final tick, `als_in` and `white_in` are captured into `als_out` and `white_out`. `res_valid` is high for exactly the one following cycle.
- R7: The code, mode and enable inputs are sampled when a window opens. A change during a window or during an idle period first affects the next window to open.
- R8: While `shutdown` is high, `integ_en` is low, no result is produced and both outputs hold their last values. A window in progress is abandoned without capture.
- R9: The first clock edge that samples `shutdown` low opens a new window, and its results replace the held data after one integration time.
- R10: Windows and idle periods advance only on cycles where `ms_tick` is high. Cycles without a tick lengthen the period by the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| it_code | input | 4 | Integration-time code |
| psm_mode | input | 2 | Idle-period select |
| psm_en | input | 1 | Power-saving enable |
| shutdown | input | 1 | Stop measuring, hold results |
| als_in | input | DW | Ambient result from the front end |
| white_in | input | DW | White-channel result from the front end |
| integ_en | output | 1 | High while a window integrates |
| res_valid | output | 1 | One-cycle pulse after results are captured |
| als_out | output | DW | Held ambient result |
| white_out | output | DW | Held white-channel result |

## Verification
Several properties are checked on every cycle by assertions:
- the single-cycle strobe;
- frozen outputs and no integration under shutdown;
- no progress on cycles without a tick;
- a window length that never changes mid-window;
- a tick counter that stays below the latched length.

The absolute period values can only be shown by the bench's scenarios, by measuring the spacing between strobes and comparing captured data. These include:
- each code's decoded length and the fallback for unlisted codes;
- the idle length for each mode;
- which window first sees a configuration change;
- first-result latency after wake.

// File: rtl/meas_sched.sv
module meas_sched #(
  parameter int DW        = 16,
  parameter int CW        = 13,
  parameter int IDLE_UNIT = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic [3:0]    it_code,
  input  logic [1:0]    psm_mode,
  input  logic          psm_en,
  input  logic          shutdown,
  input  logic [DW-1:0] als_in,
  input  logic [DW-1:0] white_in,
  output logic          integ_en,
  output logic          res_valid,
  output logic [DW-1:0] als_out,
  output logic [DW-1:0] white_out
);

  typedef enum logic [1:0] {S_SHUT, S_INT, S_IDLE} state_t;

  state_t        state;
  logic [CW-1:0] cnt, win_len, idle_len;
  logic          psm_l;

  function automatic logic [CW-1:0] it_len(input logic [3:0] code);
    case (code)
      4'b1100: it_len = CW'(25);
      4'b1000: it_len = CW'(50);
      4'b0001: it_len = CW'(200);
      4'b0010: it_len = CW'(400);
      4'b0011: it_len = CW'(800);
      default: it_len = CW'(100);
    endcase
  endfunction

  wire [CW-1:0] next_idle = CW'(IDLE_UNIT) << psm_mode;
  wire          win_done  = ms_tick && (cnt == win_len - CW'(1));
  wire          idle_done = ms_tick && (cnt == idle_len - CW'(1));

  assign integ_en = (state == S_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_SHUT;
      cnt       <= '0;
      win_len   <= CW'(100);
      idle_len  <= CW'(IDLE_UNIT);
      psm_l     <= 1'b0;
      res_valid <= 1'b0;
      als_out   <= '0;
      white_out <= '0;
    end else begin
      res_valid <= 1'b0;
      if (shutdown) begin
        state <= S_SHUT;
        cnt   <= '0;
      end else begin
        case (state)
          S_SHUT: begin
            state    <= S_INT;
            cnt      <= '0;
            win_len  <= it_len(it_code);
            idle_len <= next_idle;
            psm_l    <= psm_en;
          end
          S_INT: if (ms_tick) begin
            if (win_done) begin
              als_out   <= als_in;
              white_out <= white_in;
              res_valid <= 1'b1;
              cnt       <= '0;
              if (psm_l) begin
                state <= S_IDLE;
              end else begin
                win_len  <= it_len(it_code);
                idle_len <= next_idle;
                psm_l    <= psm_en;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          S_IDLE: if (ms_tick) begin
            if (idle_done) begin
              state    <= S_INT;
              cnt      <= '0;
              win_len  <= it_len(it_code);
              idle_len <= next_idle;
              psm_l    <= psm_en;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: state <= S_SHUT;
        endcase
      end
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_valid_after_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(integ_en));

  assert_shut_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!integ_en && !res_valid && $stable(als_out) && $stable(white_out)));

  assert_no_tick_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && !shutdown) |=> ($stable(cnt) && !res_valid));

  assert_len_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_en && $past(integ_en) && !res_valid) |-> $stable(win_len));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    integ_en |-> (cnt < win_len));

endmodule

// File: tb/sim_meas_sched.sv
`timescale 1ns/1ps
module sim_meas_sched;
  logic clk = 0, rst_n = 0, ms_tick = 1, psm_en = 0, shutdown = 1;
  logic [3:0]  it_code = 4'b0000;
  logic [1:0]  psm_mode = 2'b00;
  logic [15:0] als_in = '0, white_in = '0;
  logic        integ_en, res_valid;
  logic [15:0] als_out, white_out;

  always #4 clk = ~clk;

  meas_sched u0 (.clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .it_code(it_code),
    .psm_mode(psm_mode), .psm_en(psm_en), .shutdown(shutdown), .als_in(als_in),
    .white_in(white_in), .integ_en(integ_en), .res_valid(res_valid),
    .als_out(als_out), .white_out(white_out));

  typedef struct { int gap; logic [15:0] a; logic [15:0] w; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0, last_ref = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int gap, input logic [15:0] a, input logic [15:0] w, input string tag);
    exp_t e;
    e.gap = gap; e.a = a; e.w = w; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid && !done) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check((cyc - last_ref) == e.gap, e.tag, cyc - last_ref, e.gap);
        check(als_out == e.a && white_out == e.w, e.tag, int'(als_out), int'(e.a));
      end
      last_ref = cyc;
    end
  end

  task automatic wake();
    last_ref = cyc + 1;
    shutdown = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(integ_en == 0 && res_valid == 0 && als_out == 0 && white_out == 0, "R1 reset", int'(integ_en), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(integ_en == 0 && als_out == 0, "R1 stays shut", int'(integ_en), 0);

    als_in = 16'h1234; white_in = 16'h5678;
    it_code = 4'b1100;
    wake();
    @(negedge clk);
    check(integ_en == 1, "R9 window opens", int'(integ_en), 1);
    push(25, 16'h1234, 16'h5678, "R9 first result");
    push(25, 16'h1234, 16'h5678, "R4 back to back 25");
    drain();
    it_code = 4'b1000;
    push(25, 16'h1234, 16'h5678, "R7 current window kept");
    push(50, 16'h1234, 16'h5678, "R2 code 1000 is 50");
    drain();
    it_code = 4'b0101;
    push(50, 16'h1234, 16'h5678, "R7 old length 50");
    push(100, 16'h1234, 16'h5678, "R3 unlisted code 100");
    drain();
    it_code = 4'b0000; psm_en = 1; psm_mode = 2'b00;
    push(100, 16'h1234, 16'h5678, "R7 psm off window");
    push(100, 16'h1234, 16'h5678, "R2 code 0000 is 100");
    push(600, 16'h1234, 16'h5678, "R5 mode 00 period 600");
    drain();
    check(integ_en == 0, "R5 idle integ_en low", int'(integ_en), 0);
    it_code = 4'b0011; psm_mode = 2'b11;
    push(1300, 16'h1234, 16'h5678, "R7 idle 500 then 800");
    push(4800, 16'h1234, 16'h5678, "R5 mode 11 period 4800");
    drain();

    shutdown = 1;
    als_in = 16'hAAAA; white_in = 16'hBBBB;
    repeat (50) @(negedge clk);
    check(integ_en == 0, "R8 no integrate in shutdown", int'(integ_en), 0);
    check(als_out == 16'h1234 && white_out == 16'h5678, "R8 held data", int'(als_out), 16'h1234);

    it_code = 4'b1100; psm_en = 0;
    wake();
    push(25, 16'hAAAA, 16'hBBBB, "R9 wake refresh");
    drain();
    ms_tick = 0;
    repeat (20) @(negedge clk);
    check(integ_en == 1, "R10 stalled window stays open", int'(integ_en), 1);
    ms_tick = 1;
    push(45, 16'hAAAA, 16'hBBBB, "R10 no tick no progress");
    drain();
    repeat (8) @(negedge clk);
    shutdown = 1;
    als_in = 16'hCCCC; white_in = 16'hDDDD;
    repeat (40) @(negedge clk);
    check(als_out == 16'hAAAA && white_out == 16'hBBBB, "R8 abandoned window no capture", int'(als_out), 16'hAAAA);
    check(res_valid == 0 && integ_en == 0, "R8 idle outputs", int'(integ_en), 0);
    check(q.size() == 0, "R6 all results seen", q.size(), 0);
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    report();
  end
endmodule